// File: doc/BRIEF.md
# Memory Region Hazard Scoreboard

This block lets a host processor keep running while a reconfigurable unit carries out memory-to-memory operations. Each operation reads one aligned block of memory and writes another. When the operation is issued, both blocks are recorded in a small table. A block is given as a base address and a size code equal to log2 of its byte count. The size code is clamped to the range 4..12. The block covered is the aligned span that contains the base, so the base bits below the size are ignored.

Every host load and store is compared against the live entries. The host is held off whenever letting the access through would break program order:

- a load waits on a pending write region;
- a store waits on any pending region.

A new unit operation is refused in two cases: its read block overlaps a pending write region, or its write block overlaps any pending region. Each entry is independent. An entry is freed on the clock after the unit reports completion with that entry's index.

Issue is a valid/ready stream. An operation is taken on a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low, the issuer must hold the operation and its fields steady. `iss_ready` does not depend on `iss_valid`. The host side also uses valid/ready. An access completes on a cycle where `host_valid` and `host_ready` are both high. A host access must stay valid and unchanged until it completes. Completion is a plain one-cycle strobe.

Top module: `region_scoreboard`

## Requirements
- R1: An accepted issue goes to the lowest-numbered free entry. That number is shown on `iss_idx` in the accept cycle, and the entry is live from the next cycle.
- R2: `sb_full` is high exactly when all 4 entries are live. While `sb_full` is high, `iss_ready` is low, even for an operation with no overlap.
- R3: A load (`host_write`=0) whose byte address lies inside a live write region gets `host_ready`=0.
- R4: A load that lies only inside live read regions, or outside all live regions, gets `host_ready`=1.
- R5: A store (`host_write`=1) whose address lies inside any live read or write region gets `host_ready`=0. Any other store gets `host_ready`=1.
- R6: An issue whose read block overlaps a live write region gets `iss_ready`=0.
- R7: An issue whose write block overlaps a live read or write region gets `iss_ready`=0.
- R8: An issue whose read block overlaps only live read regions is accepted.
- R9: A `done_valid` pulse frees entry `done_idx` at that clock edge. From the next cycle on, accesses that were held only by that entry proceed and `sb_full` drops.
- R10: A size code below 4 is taken as 4, and a code above 12 is taken as 12. A region covers the aligned block base & ~(2^size-1) through that value plus 2^size-1.
- R11: A completion naming a free entry changes nothing: `sb_full` and the stalls from the other entries stay as they were.
- R12: A host access in the same cycle as an issue is ordered before that issue and is not held by it. From the next cycle it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Unit operation offered |
| iss_ready | output | 1 | Operation can be accepted (not full, no overlap) |
| iss_src_addr | input | 32 | Read block base address |
| iss_src_log | input | 4 | Read block size code (log2 bytes) |
| iss_dst_addr | input | 32 | Write block base address |
| iss_dst_log | input | 4 | Write block size code (log2 bytes) |
| iss_idx | output | 2 | Entry that an accept in this cycle takes |
| sb_full | output | 1 | All entries live |
| host_valid | input | 1 | Host access offered |
| host_write | input | 1 | 1 for store, 0 for load |
| host_addr | input | 32 | Host byte address |
| host_ready | output | 1 | Host access may proceed |
| done_valid | input | 1 | Unit completion strobe |
| done_idx | input | 2 | Entry that completed |

## Verification
Loads and stores are aimed at addresses just inside and just outside each pending block, and at read-only blocks as well as write blocks. This separates read-after-write stalls from write-after-read and write-after-write stalls, and it shows where each region ends. New operations are offered with read and write blocks that land on pending read blocks, on pending write blocks, on unaligned bases and on out-of-range size codes. This checks each issue hazard rule and the clamping on its own. Completion is then tested on a live entry, on an entry that is already free, and with an issue and a host access in the same cycle. These cases show the release timing, the reuse of freed entries in index order, and how same-cycle events are ordered.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int ADDR_W = 32;
  localparam int SZ_W   = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SZ_W-1:0]   szlog_t;

  typedef struct packed {
    addr_t  base;
    szlog_t lg;
  } region_t;

  // Two aligned power-of-two blocks overlap exactly when they agree above the larger size.
  function automatic logic region_overlap(region_t a, region_t b);
    szlog_t big;
    addr_t  keep;
    big  = (a.lg > b.lg) ? a.lg : b.lg;
    keep = ~((addr_t'(1) << big) - addr_t'(1));
    return (a.base & keep) == (b.base & keep);
  endfunction
endpackage

// File: rtl/sb_match.sv
module sb_match
  import sb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  region_t                  probe,
  input  region_t [ENTRIES-1:0]    src_tab,
  input  region_t [ENTRIES-1:0]    dst_tab,
  input  logic    [ENTRIES-1:0]    live,
  output logic                     hit_src,
  output logic                     hit_dst
);
  logic [ENTRIES-1:0] s_vec;
  logic [ENTRIES-1:0] d_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign s_vec[g] = live[g] && region_overlap(probe, src_tab[g]);
    assign d_vec[g] = live[g] && region_overlap(probe, dst_tab[g]);
  end

  assign hit_src = |s_vec;
  assign hit_dst = |d_vec;
endmodule

// File: rtl/sb_alloc.sv
module sb_alloc #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] live,
  output logic [IDX_W-1:0]   pick,
  output logic               none_free
);
  always_comb begin
    pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) pick = IDX_W'(i);
    end
  end

  assign none_free = &live;
endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard
  import sb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LOG_MIN = 4,
  parameter int LOG_MAX = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [ADDR_W-1:0] iss_src_addr,
  input  logic [SZ_W-1:0]   iss_src_log,
  input  logic [ADDR_W-1:0] iss_dst_addr,
  input  logic [SZ_W-1:0]   iss_dst_log,
  output logic [IDX_W-1:0]  iss_idx,
  output logic              sb_full,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_ready,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx
);
  function automatic szlog_t clamp_log(szlog_t v);
    if (int'(v) < LOG_MIN) return szlog_t'(LOG_MIN);
    if (int'(v) > LOG_MAX) return szlog_t'(LOG_MAX);
    return v;
  endfunction

  logic    [ENTRIES-1:0] live;
  region_t [ENTRIES-1:0] src_tab;
  region_t [ENTRIES-1:0] dst_tab;

  region_t new_src, new_dst, host_pt;
  assign new_src = '{base: iss_src_addr, lg: clamp_log(iss_src_log)};
  assign new_dst = '{base: iss_dst_addr, lg: clamp_log(iss_dst_log)};
  assign host_pt = '{base: host_addr, lg: '0};

  logic h_src, h_dst, ns_src, ns_dst, nd_src, nd_dst;

  sb_match #(.ENTRIES(ENTRIES)) u_host (
    .probe(host_pt), .src_tab(src_tab), .dst_tab(dst_tab), .live(live),
    .hit_src(h_src), .hit_dst(h_dst));

  sb_match #(.ENTRIES(ENTRIES)) u_nsrc (
    .probe(new_src), .src_tab(src_tab), .dst_tab(dst_tab), .live(live),
    .hit_src(ns_src), .hit_dst(ns_dst));

  sb_match #(.ENTRIES(ENTRIES)) u_ndst (
    .probe(new_dst), .src_tab(src_tab), .dst_tab(dst_tab), .live(live),
    .hit_src(nd_src), .hit_dst(nd_dst));

  logic [IDX_W-1:0] free_idx;
  logic             all_busy;

  sb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .live(live), .pick(free_idx), .none_free(all_busy));

  logic iss_clash;
  assign iss_clash  = ns_dst | nd_src | nd_dst;
  assign iss_ready  = !all_busy && !iss_clash;
  assign iss_idx    = free_idx;
  assign sb_full    = all_busy;
  assign host_ready = !(h_dst || (host_write && h_src));

  logic accept;
  assign accept = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live    <= '0;
      src_tab <= '0;
      dst_tab <= '0;
    end else begin
      if (done_valid) live[done_idx] <= 1'b0;
      if (accept) begin
        live[free_idx]    <= 1'b1;
        src_tab[free_idx] <= new_src;
        dst_tab[free_idx] <= new_dst;
      end
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic [IDX_W-1:0]   iss_idx,
  input logic               sb_full,
  input logic               host_ready,
  input logic               done_valid,
  input logic [IDX_W-1:0]   done_idx,
  input logic [ENTRIES-1:0] live
);
  logic take;
  assign take = iss_valid && iss_ready;

  AST_FULL_STOPS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_full |-> !iss_ready); // R2
  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !live[iss_idx]); // R1
  AST_ALLOC_GOES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> live[$past(iss_idx)]); // R1
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !(take && iss_idx == done_idx)) |=> !live[$past(done_idx)]); // R9
  AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (host_ready && !sb_full)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !done_valid) |=> ($countones(live) == $countones($past(live)) + 1)); // R1
endmodule

bind region_scoreboard sb_checker #(.ENTRIES(ENTRIES)) u_sb_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_idx(iss_idx), .sb_full(sb_full), .host_ready(host_ready),
  .done_valid(done_valid), .done_idx(done_idx), .live(live));

// File: tb/region_scoreboard_test.sv
module region_scoreboard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [31:0] iss_src_addr = '0;
  logic [3:0]  iss_src_log = '0;
  logic [31:0] iss_dst_addr = '0;
  logic [3:0]  iss_dst_log = '0;
  logic [1:0]  iss_idx;
  logic        sb_full;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [31:0] host_addr = '0;
  logic        host_ready;
  logic        done_valid = 1'b0;
  logic [1:0]  done_idx = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  region_scoreboard uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_addr(iss_src_addr), .iss_src_log(iss_src_log),
    .iss_dst_addr(iss_dst_addr), .iss_dst_log(iss_dst_log),
    .iss_idx(iss_idx), .sb_full(sb_full), .host_valid(host_valid),
    .host_write(host_write), .host_addr(host_addr), .host_ready(host_ready),
    .done_valid(done_valid), .done_idx(done_idx));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Offer an operation; check readiness and index; clock it in.
  task automatic issue(input logic [31:0] s, input logic [3:0] sl,
                       input logic [31:0] d, input logic [3:0] dl,
                       input int exp_ok, input int exp_idx, input string tag);
    @(negedge clk);
    iss_src_addr = s; iss_src_log = sl; iss_dst_addr = d; iss_dst_log = dl;
    iss_valid = 1'b1;
    #1;
    chk({tag, " ready"}, int'(iss_ready), exp_ok);
    if (exp_ok != 0) chk({tag, " idx"}, int'(iss_idx), exp_idx);
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic wr, input int exp_ok,
                       input string tag);
    @(negedge clk);
    host_addr = a; host_write = wr; host_valid = 1'b1;
    #1;
    chk(tag, int'(host_ready), exp_ok);
    host_valid = 1'b0;
  endtask

  task automatic complete(input logic [1:0] idx);
    @(negedge clk);
    done_idx = idx; done_valid = 1'b1;
    @(posedge clk);
    #1 done_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R2 reset full", int'(sb_full), 0);
    chk("R1 reset iss_ready", int'(iss_ready), 1);
    chk("R4 reset host_ready", int'(host_ready), 1);
  endtask

  task automatic t_host_hazards();
    issue(32'h1000, 4'd8, 32'h2000, 4'd8, 1, 0, "R1 first issue");
    probe(32'h2040, 1'b0, 0, "R3 load in dst");
    probe(32'h20FF, 1'b0, 0, "R3 load last dst byte");
    probe(32'h2100, 1'b0, 1, "R4 load past dst");
    probe(32'h1040, 1'b0, 1, "R4 load in src");
    probe(32'h1040, 1'b1, 0, "R5 store in src");
    probe(32'h2080, 1'b1, 0, "R5 store in dst");
    probe(32'h3000, 1'b1, 1, "R5 store clear");
  endtask

  task automatic t_issue_hazards();
    issue(32'h2080, 4'd4, 32'h5000, 4'd4, 0, 0, "R6 src on dst");
    issue(32'h5000, 4'd4, 32'h1000, 4'd4, 0, 0, "R7 dst on src");
    issue(32'h5000, 4'd4, 32'h20F0, 4'd4, 0, 0, "R7 dst on dst");
    issue(32'h1000, 4'd6, 32'h4000, 4'd8, 1, 1, "R8 shared src");
    issue(32'h6000, 4'd4, 32'h4055, 4'd8, 0, 0, "R10 unaligned dst");
  endtask

  task automatic t_sizes_and_full();
    issue(32'h6000, 4'd4, 32'hA000, 4'd2, 1, 2, "R10 small code");
    issue(32'h6100, 4'd4, 32'hB000, 4'd15, 1, 3, "R10 big code");
    probe(32'hA00C, 1'b0, 0, "R10 clamp low inside");
    probe(32'hA010, 1'b0, 1, "R10 clamp low outside");
    probe(32'hBFF0, 1'b0, 0, "R10 clamp high inside");
    probe(32'hC000, 1'b0, 1, "R10 clamp high outside");
    @(negedge clk);
    chk("R2 full set", int'(sb_full), 1);
    issue(32'hE000, 4'd4, 32'hF000, 4'd4, 0, 0, "R2 full blocks");
  endtask

  task automatic t_complete();
    complete(2'd0);
    @(negedge clk);
    chk("R9 full drops", int'(sb_full), 0);
    probe(32'h2040, 1'b0, 1, "R9 load released");
    complete(2'd0);
    @(negedge clk);
    chk("R11 full unchanged", int'(sb_full), 0);
    probe(32'hA00C, 1'b0, 0, "R11 other stall kept");
    issue(32'h7000, 4'd4, 32'h7800, 4'd4, 1, 0, "R1 reuse lowest");
  endtask

  task automatic t_same_cycle();
    complete(2'd1);
    @(negedge clk);
    iss_src_addr = 32'h7400; iss_src_log = 4'd4;
    iss_dst_addr = 32'hD000; iss_dst_log = 4'd4; iss_valid = 1'b1;
    host_addr = 32'hD000; host_write = 1'b0; host_valid = 1'b1;
    #1;
    chk("R12 host not held", int'(host_ready), 1);
    chk("R12 issue ready", int'(iss_ready), 1);
    chk("R12 issue idx", int'(iss_idx), 1);
    @(posedge clk);
    #1 iss_valid = 1'b0;
    @(negedge clk);
    chk("R12 host held after", int'(host_ready), 0);
    host_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_host_hazards();
    t_issue_hazards();
    t_sizes_and_full();
    t_complete();
    t_same_cycle();
    repeat (2) @(posedge clk);
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      finish_run();
    end
  end
endmodule